// File: doc/BRIEF.md
# UART Status Flags with Clear Sequence

This block holds the byte-wide line status of a UART together with a byte of FIFO status. Level conditions from the transmit and receive paths are copied into the status byte every cycle: holding register empty, transmitter fully idle, receive data present and line idle. Four error conditions are kept sticky once they have occurred: overrun, noise, framing and parity. The block that detects an error gives a one-cycle pulse, and the flag then stays set.

Software clears the error flags in two steps. It reads the status byte and then reads the data byte. The clear goes ahead only if nothing disturbs it in between: a new error event or a data write cancels it. An error that arrives in the same cycle as the clearing read survives.

The FIFO status byte shows whether the transmit and receive FIFOs are empty. It also holds three sticky FIFO fault flags: receive overflow, transmit overflow and receive underflow. Software clears these by writing a one to their positions. A three-bit enable, laid out on the same positions, gates them onto an interrupt line. All pins are plain control and status wires. Nothing in the block carries a data stream, so there is no valid/ready handshake.

Top module: `uart_stat_flags`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `stat_q`, `fifo_stat` and `fifo_irq` are all zero.
- R2: `stat_q[7]` equals `tx_hold_empty`, `stat_q[5]` equals `rx_data_full` and `stat_q[4]` equals `rx_line_idle`, each as sampled at the previous clock edge.
- R3: `stat_q[6]` (transmission complete) is 1 only if, at the previous edge, `tx_hold_empty` was 1 and `tx_shift_busy` was 0. Otherwise it is 0.
- R4: A pulse on `err_evt[3]` (overrun), `err_evt[2]` (noise), `err_evt[1]` (framing) or `err_evt[0]` (parity) sets the same bit of `stat_q[3:0]` one cycle later. The bit stays set until it is cleared as R5 describes.
- R5: A `stat_rd` pulse followed later by a `data_rd` pulse clears `stat_q[3:0]` on the cycle after the `data_rd`. This happens only if no error event and no `data_wr` occur in between. A `data_rd` consumes the armed state.
- R6: A `data_rd` with no `stat_rd` since the last error event, the last write or the last data read leaves `stat_q[3:0]` unchanged.
- R7: An error event that arrives after the `stat_rd` and before the `data_rd` cancels the pending clear.
- R8: A `data_wr` that arrives after the `stat_rd` and before the `data_rd` cancels the pending clear.
- R9: If an error event arrives in the same cycle as a clearing `data_rd`, that flag is set afterwards and the other error flags are cleared.
- R10: `fifo_stat[7]` equals `txf_empty` and `fifo_stat[6]` equals `rxf_empty`, each from the previous edge. Bits 5 to 3 of `fifo_stat` are always 0.
- R11: A pulse on `fifo_evt[2]` (receive overflow), `fifo_evt[1]` (transmit overflow) or `fifo_evt[0]` (receive underflow) sets the same bit of `fifo_stat` one cycle later. When `fifo_wr` is high, each bit set in `fifo_clr` clears the matching flag, unless an event for that bit arrives in the same cycle.
- R12: `fifo_irq` is high in the same cycle whenever any of `fifo_stat[2:0]` is set together with the matching bit of `fifo_irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_hold_empty | input | 1 | Transmit holding register can take a byte |
| tx_shift_busy | input | 1 | A character is still shifting out |
| rx_data_full | input | 1 | Received data is waiting |
| rx_line_idle | input | 1 | Receive line idle detected |
| err_evt | input | 4 | Error pulses: overrun, noise, framing, parity (bit 3 to bit 0) |
| stat_rd | input | 1 | Software read of the status byte |
| data_rd | input | 1 | Software read of the data byte |
| data_wr | input | 1 | Software write of the data byte |
| stat_q | output | 8 | Line status byte |
| txf_empty | input | 1 | Transmit FIFO empty |
| rxf_empty | input | 1 | Receive FIFO empty |
| fifo_evt | input | 3 | FIFO fault pulses: receive overflow, transmit overflow, receive underflow |
| fifo_wr | input | 1 | Write strobe for clearing FIFO faults |
| fifo_clr | input | 3 | Write-one-to-clear mask aligned with fifo_stat[2:0] |
| fifo_irq_en | input | 3 | Interrupt enables aligned with fifo_stat[2:0] |
| fifo_stat | output | 8 | FIFO status byte |
| fifo_irq | output | 1 | FIFO fault interrupt |

## Verification
Every flag in both status bytes is a single register. The result of a stimulus applied before a clock edge is therefore due on the outputs right after that edge, and `fifo_irq` follows `fifo_irq_en` in the same cycle. The bench drives its inputs just after a falling edge and compares at the following falling edge, one full edge after the stimulus. It compares against a behavioural model that advances on the same rising edge. The clear sequences are laid out with gaps of whole cycles, so that each cancelling event lands strictly between the status read and the data read, or exactly on the data read.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
  localparam int STAT_W   = 8;
  localparam int ERR_N    = 4;
  localparam int FFLT_N   = 3;
  // bit positions in the line status byte
  localparam int B_TDRE   = 7;
  localparam int B_TC     = 6;
  localparam int B_RXF    = 5;
  localparam int B_IDLE   = 4;
  // bit positions in the FIFO status byte
  localparam int B_TXEMP  = 7;
  localparam int B_RXEMP  = 6;
  typedef logic [ERR_N-1:0]  err_vec_t;
  typedef logic [FFLT_N-1:0] fflt_vec_t;
  typedef logic [STAT_W-1:0] stat_byte_t;
endpackage

// File: rtl/uart_err_flags.sv
module uart_err_flags
  import uart_stat_pkg::*;
#(
  parameter int N = ERR_N
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic         stat_rd,
  input  logic         data_rd,
  input  logic         data_wr,
  output logic [N-1:0] flags,
  output logic         armed
);
  logic arm_q;
  logic any_evt;
  logic clr_now;

  assign any_evt = |evt;
  assign clr_now = data_rd & arm_q;

  // arming: a status read arms; events, writes and data reads disarm
  always_ff @(posedge clk) begin
    if (rst)                    arm_q <= 1'b0;
    else if (any_evt || data_wr) arm_q <= 1'b0;
    else if (stat_rd)           arm_q <= 1'b1;
    else if (data_rd)           arm_q <= 1'b0;
  end

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_flag
      logic f_q;
      always_ff @(posedge clk) begin
        if (rst)          f_q <= 1'b0;
        else if (evt[i])  f_q <= 1'b1;
        else if (clr_now) f_q <= 1'b0;
      end
      assign flags[i] = f_q;
    end
  endgenerate

  assign armed = arm_q;

  // R4: an event shows up on the flag one cycle later
  a_r4_evt_sets: assert property (@(posedge clk) disable iff (rst)
    any_evt |=> ((flags & $past(evt)) == $past(evt)));
  // R6: no flag may fall unless an armed data read happened
  a_r6_fall_needs_arm: assert property (@(posedge clk) disable iff (rst)
    !(data_rd && armed) |=> ((flags & $past(flags)) == $past(flags)));
  // R8: a data write always leaves the sequence disarmed
  a_r8_write_disarms: assert property (@(posedge clk) disable iff (rst)
    data_wr |=> !armed);
endmodule

// File: rtl/uart_fifo_flags.sv
module uart_fifo_flags
  import uart_stat_pkg::*;
#(
  parameter int N = FFLT_N
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic         wr,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] clr_mask;
  assign clr_mask = wr ? clr : '0;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_fault
      logic f_q;
      always_ff @(posedge clk) begin
        if (rst)              f_q <= 1'b0;
        else if (evt[i])      f_q <= 1'b1;
        else if (clr_mask[i]) f_q <= 1'b0;
      end
      assign flags[i] = f_q;
    end
  endgenerate

  assign irq = |(flags & en);

  // R11: a fault flag falls only where a clear bit was written
  a_r11_w1c_only: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(flags) & ~flags & ~$past(clr_mask)) == '0));
  // R11: an event in the same cycle as a clear wins
  a_r11_evt_wins: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((flags & $past(evt)) == $past(evt)));
endmodule

// File: rtl/uart_stat_flags.sv
module uart_stat_flags
  import uart_stat_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                tx_hold_empty,
  input  logic                tx_shift_busy,
  input  logic                rx_data_full,
  input  logic                rx_line_idle,
  input  logic [ERR_N-1:0]    err_evt,
  input  logic                stat_rd,
  input  logic                data_rd,
  input  logic                data_wr,
  output logic [STAT_W-1:0]   stat_q,
  input  logic                txf_empty,
  input  logic                rxf_empty,
  input  logic [FFLT_N-1:0]   fifo_evt,
  input  logic                fifo_wr,
  input  logic [FFLT_N-1:0]   fifo_clr,
  input  logic [FFLT_N-1:0]   fifo_irq_en,
  output logic [STAT_W-1:0]   fifo_stat,
  output logic                fifo_irq
);
  logic tdre_q, tc_q, rxf_q, idle_q, txe_q, rxe_q;
  err_vec_t  err_flags;
  fflt_vec_t fflt;
  logic      err_armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      tdre_q <= 1'b0;
      tc_q   <= 1'b0;
      rxf_q  <= 1'b0;
      idle_q <= 1'b0;
      txe_q  <= 1'b0;
      rxe_q  <= 1'b0;
    end else begin
      tdre_q <= tx_hold_empty;
      tc_q   <= tx_hold_empty & ~tx_shift_busy;
      rxf_q  <= rx_data_full;
      idle_q <= rx_line_idle;
      txe_q  <= txf_empty;
      rxe_q  <= rxf_empty;
    end
  end

  uart_err_flags #(.N(ERR_N)) u_err (
    .clk(clk), .rst(rst), .evt(err_evt), .stat_rd(stat_rd),
    .data_rd(data_rd), .data_wr(data_wr), .flags(err_flags),
    .armed(err_armed)
  );

  uart_fifo_flags #(.N(FFLT_N)) u_fifo (
    .clk(clk), .rst(rst), .evt(fifo_evt), .wr(fifo_wr), .clr(fifo_clr),
    .en(fifo_irq_en), .flags(fflt), .irq(fifo_irq)
  );

  always_comb begin
    stat_q              = '0;
    stat_q[B_TDRE]      = tdre_q;
    stat_q[B_TC]        = tc_q;
    stat_q[B_RXF]       = rxf_q;
    stat_q[B_IDLE]      = idle_q;
    stat_q[ERR_N-1:0]   = err_flags;
    fifo_stat           = '0;
    fifo_stat[B_TXEMP]  = txe_q;
    fifo_stat[B_RXEMP]  = rxe_q;
    fifo_stat[FFLT_N-1:0] = fflt;
  end

  // R3: complete only when the transmitter was fully idle
  a_r3_tc_idle: assert property (@(posedge clk) disable iff (rst)
    stat_q[B_TC] |-> $past(tx_hold_empty && !tx_shift_busy));
  // R3: complete never while a character is shifting
  a_r3_tc_busy: assert property (@(posedge clk) disable iff (rst)
    tx_shift_busy |=> !stat_q[B_TC]);
  // R10: the unused FIFO status bits stay low
  a_r10_gap_zero: assert property (@(posedge clk) disable iff (rst)
    fifo_stat[5:3] == 3'b000);
endmodule

// File: tb/tb_uart_stat_flags.sv
module tb_uart_stat_flags;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_hold_empty = 0, tx_shift_busy = 0, rx_data_full = 0, rx_line_idle = 0;
  logic [3:0] err_evt = '0;
  logic stat_rd = 0, data_rd = 0, data_wr = 0;
  logic txf_empty = 0, rxf_empty = 0;
  logic [2:0] fifo_evt = '0, fifo_clr = '0, fifo_irq_en = '0;
  logic fifo_wr = 0;
  logic [7:0] stat_q, fifo_stat;
  logic fifo_irq;

  always #(CLK_P/2) clk = ~clk;

  uart_stat_flags dut (
    .clk(clk), .rst(rst), .tx_hold_empty(tx_hold_empty), .tx_shift_busy(tx_shift_busy),
    .rx_data_full(rx_data_full), .rx_line_idle(rx_line_idle), .err_evt(err_evt),
    .stat_rd(stat_rd), .data_rd(data_rd), .data_wr(data_wr), .stat_q(stat_q),
    .txf_empty(txf_empty), .rxf_empty(rxf_empty), .fifo_evt(fifo_evt),
    .fifo_wr(fifo_wr), .fifo_clr(fifo_clr), .fifo_irq_en(fifo_irq_en),
    .fifo_stat(fifo_stat), .fifo_irq(fifo_irq)
  );

  // behavioural reference
  int m_hi;        // line status bits 7..4
  int m_err;       // error flags 3..0
  int m_ffe;       // fifo bits 7..6
  int m_flt;       // fifo faults 2..0
  bit m_arm;
  int total = 0, bad = 0;
  string tag = "R4";
  bit done = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_hi = 0; m_err = 0; m_ffe = 0; m_flt = 0; m_arm = 0;
    end else begin
      bit clear_now;
      clear_now = data_rd && m_arm;
      m_hi = (tx_hold_empty << 3) | ((tx_hold_empty && !tx_shift_busy) << 2)
           | (rx_data_full << 1) | rx_line_idle;
      for (int b = 0; b < 4; b++) begin
        if (err_evt[b]) m_err = m_err | (1 << b);
        else if (clear_now) m_err = m_err & ~(1 << b);
      end
      if (err_evt != 0 || data_wr) m_arm = 0;
      else if (stat_rd) m_arm = 1;
      else if (data_rd) m_arm = 0;
      m_ffe = (txf_empty << 1) | rxf_empty;
      for (int b = 0; b < 3; b++) begin
        if (fifo_evt[b]) m_flt = m_flt | (1 << b);
        else if (fifo_wr && fifo_clr[b]) m_flt = m_flt & ~(1 << b);
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // compare everything, then release the one-cycle pulses
  task automatic step();
    @(negedge clk);
    if (rst || tag == "R1") begin
      chk("R1", {stat_q, fifo_stat, 7'd0, fifo_irq}, 0);
    end else begin
      chk("R2", {stat_q[7], stat_q[5], stat_q[4]},
          {m_hi[3], m_hi[1], m_hi[0]});
      chk("R3", stat_q[6], m_hi[2]);
      chk(tag, stat_q[3:0], m_err);
      chk("R10", fifo_stat[7:3], m_ffe << 3);
      chk("R11", fifo_stat[2:0], m_flt);
      chk("R12", fifo_irq, ((m_flt & fifo_irq_en) != 0));
    end
    err_evt = '0; stat_rd = 0; data_rd = 0; data_wr = 0;
    fifo_evt = '0; fifo_wr = 0; fifo_clr = '0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    if (!done) $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    tag = "R1";
    tx_hold_empty = 1; rx_data_full = 1; err_evt = 4'hF; fifo_evt = 3'h7;
    txf_empty = 1; fifo_irq_en = 3'h7;
    @(negedge clk); @(negedge clk);
    chk("R1", {stat_q, fifo_stat, 7'd0, fifo_irq}, 0);
    err_evt = '0; fifo_evt = '0;
    tx_hold_empty = 0; rx_data_full = 0; txf_empty = 0; fifo_irq_en = 0;
    rst = 0;
    step();            // first cycle after reset: all still zero
    tag = "R4";
    // R2 / R3 level patterns
    tx_hold_empty = 1; tx_shift_busy = 1; step();
    tx_shift_busy = 0; step();
    rx_data_full = 1; rx_line_idle = 1; tx_hold_empty = 0; step();
    tx_hold_empty = 1; step(); idle(2);
    // R4 sticky set
    err_evt = 4'b1000; step(); idle(3);
    err_evt = 4'b0001; step(); idle(1);
    // R6 data read alone
    tag = "R6"; data_rd = 1; step(); idle(2);
    // R5 proper sequence
    tag = "R5"; stat_rd = 1; step(); idle(2); data_rd = 1; step(); idle(2);
    // R7 event between
    tag = "R7"; err_evt = 4'b0010; step();
    stat_rd = 1; step(); err_evt = 4'b0100; step(); data_rd = 1; step(); idle(2);
    // R8 write between
    tag = "R8"; stat_rd = 1; step(); data_wr = 1; step(); data_rd = 1; step(); idle(2);
    // R5 clears after re-arm
    tag = "R5"; stat_rd = 1; step(); data_rd = 1; step(); idle(1);
    // R9 event same cycle as clear
    tag = "R9"; err_evt = 4'b1001; step(); stat_rd = 1; step();
    data_rd = 1; err_evt = 4'b0010; step(); idle(2);
    tag = "R5"; stat_rd = 1; step(); data_rd = 1; stat_rd = 1; step(); data_rd = 1; step(); idle(1);
    // R10 fifo empty levels
    txf_empty = 1; step(); rxf_empty = 1; txf_empty = 0; step(); idle(1);
    // R11 / R12 faults, enables, clears
    fifo_evt = 3'b101; step(); idle(1);
    fifo_irq_en = 3'b010; step();
    fifo_irq_en = 3'b100; step();
    fifo_wr = 1; fifo_clr = 3'b100; step();
    fifo_wr = 1; fifo_clr = 3'b011; fifo_evt = 3'b001; step();
    fifo_irq_en = 3'b001; step();
    fifo_wr = 1; fifo_clr = 3'b111; step();
    fifo_clr = 3'b111; step();   // mask without strobe: no effect
    fifo_evt = 3'b010; step(); fifo_clr = 3'b010; step(); idle(2);
    // mixed random traffic
    tag = "R4";
    for (int k = 0; k < 3000; k++) begin
      tx_hold_empty = $urandom_range(0, 1); tx_shift_busy = $urandom_range(0, 1);
      rx_data_full = $urandom_range(0, 1); rx_line_idle = $urandom_range(0, 1);
      err_evt = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'h0;
      stat_rd = ($urandom_range(0, 3) == 0);
      data_rd = ($urandom_range(0, 3) == 0);
      data_wr = ($urandom_range(0, 9) == 0);
      txf_empty = $urandom_range(0, 1); rxf_empty = $urandom_range(0, 1);
      fifo_evt = ($urandom_range(0, 5) == 0) ? 3'($urandom) : 3'h0;
      fifo_wr = ($urandom_range(0, 4) == 0); fifo_clr = 3'($urandom);
      fifo_irq_en = 3'($urandom);
      step();
    end
    idle(2);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule